// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block computes the memory address for one load or store operation and, for the modes that update a register, the value to write back into it. Each operation supplies an addressing-mode code, an access size, the base, index and modifier register values already read from the register file, a shared immediate field, a two-bit index shift amount, and an optional predicate test. One clock edge after the operation is offered, the result appears on registered outputs for a single cycle: the effective address, a writeback enable with its value, and a cancel flag.

A predicated operation tests one bit, the least significant bit of a predicate register, either directly or inverted. When the test fails, the operation is cancelled. The address is still reported, but no writeback is requested, so a post-increment base is not changed. All address arithmetic is done at a width set by a parameter (32 bits by default) and wraps around.

The control is a two-state machine. `ST_IDLE` means that no result is being presented. `ST_RESULT` means that a result is valid this cycle. The transitions are:
- `ST_IDLE -> ST_RESULT` when `op_valid` is high.
- `ST_RESULT -> ST_RESULT` when another operation follows back to back.
- `ST_RESULT -> ST_IDLE` when `op_valid` is low.

Top module: `agu_core`

## Requirements
- R1: Mode code 0 (base plus signed offset): the address is base plus `imm[10:0]` read as a signed value and shifted left by `size` (0 byte, 1 half, 2 word, 3 double). There is no writeback.
- R2: Mode code 1 (scaled index plus absolute): the address is (index << `shamt`) plus the full `imm`. There is no writeback.
- R3: Mode code 2 (absolute set): the address is `imm`, writeback is requested, and the writeback value equals `imm`.
- R4: Mode code 3 (post-increment by immediate): the address is the unmodified base. The writeback value is base plus `imm[3:0]` read as signed and shifted left by `size`.
- R5: Mode code 4 (post-increment by modifier): the address is the unmodified base. The writeback value is base plus modifier.
- R6: Mode code 5 (register plus register): the address is base plus (index << `shamt`). There is no writeback.
- R7: Mode code 6 (predicated offset): the address is base plus `imm[5:0]` read as unsigned and shifted left by `size`. There is no writeback.
- R8: When `pred_en` is 1, the operation passes only if `pred_lsb` differs from `pred_neg`. A failing test raises `cancel` and clears `wb_en` in every mode, while `ea` still carries the computed address. When `pred_en` is 0, `cancel` stays 0.
- R9: All sums wrap modulo 2^32, including sums with negative offsets.
- R10: The result appears exactly one cycle after `op_valid` with `res_valid` high, and `wb_en` and `cancel` are never both high. While `res_valid` is low, both flags are low.
- R11: After reset, `res_valid`, `wb_en`, `cancel`, `ea` and `wb_val` are all 0.
- R12: Mode code 7 is reserved. It gives address 0 and no writeback, and cancellation still follows R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered this cycle |
| mode | input | 3 | Addressing-mode code (R1 to R7, R12) |
| size | input | 2 | Access size as log2 of the byte count |
| shamt | input | 2 | Left shift applied to the index register |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| modifier | input | 32 | Modifier register value |
| imm | input | 32 | Immediate field, read per mode |
| pred_en | input | 1 | The operation is predicated |
| pred_neg | input | 1 | Test the inverted predicate bit |
| pred_lsb | input | 1 | Least significant bit of the predicate register |
| res_valid | output | 1 | A result is presented this cycle |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Register writeback requested |
| wb_val | output | 32 | Writeback value |
| cancel | output | 1 | The predicate test failed |

## Verification
The bench aims at the sign extension of the short offsets. A design that zero-extended the 11-bit or 4-bit immediates would land far above the base instead of just below it. It also aims at post-increment under a failing predicate: a design that let the writeback through would corrupt the base register in the bench's register file model, and every later address built from that register would then be wrong. Wrap-around sums near 0xFFFFFFFF and the size scaling of the unsigned 6-bit predicated offset are directed cases, because a missing shift or a sign-extended offset gives a wrong address there. Back-to-back operations and idle gaps check that the flags drop the moment `res_valid` does.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned OFS_S_W    = 11;
    localparam int unsigned POST_S_W   = 4;
    localparam int unsigned PRED_U_W   = 6;

    typedef enum logic [2:0] {
        AM_BASE_OFS = 3'd0,
        AM_IDX_ABS  = 3'd1,
        AM_ABS_SET  = 3'd2,
        AM_POST_IMM = 3'd3,
        AM_POST_MOD = 3'd4,
        AM_REG_REG  = 3'd5,
        AM_PRED_OFS = 3'd6,
        AM_RSVD     = 3'd7
    } amode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } agu_state_e;

endpackage

// File: rtl/agu_offset.sv
module agu_offset
    import agu_pkg::*;
#(
    parameter int unsigned AW = DEF_ADDR_W
) (
    input  amode_e               mode,
    input  logic [1:0]           size,
    input  logic [1:0]           shamt,
    input  logic [OFS_S_W-1:0]   imm_lo,
    input  logic [AW-1:0]        index,
    input  logic [AW-1:0]        modifier,
    output logic [AW-1:0]        addend
);

    localparam int unsigned PAD_S11 = AW - OFS_S_W;
    localparam int unsigned PAD_S4  = AW - POST_S_W;
    localparam int unsigned PAD_U6  = AW - PRED_U_W;

    logic [AW-1:0] s11_ext;
    logic [AW-1:0] s4_ext;
    logic [AW-1:0] u6_ext;
    logic [AW-1:0] idx_scaled;

    // sign or zero extension of each immediate flavour
    assign s11_ext = {{PAD_S11{imm_lo[OFS_S_W-1]}}, imm_lo};
    assign s4_ext  = {{PAD_S4{imm_lo[POST_S_W-1]}}, imm_lo[POST_S_W-1:0]};
    assign u6_ext  = {{PAD_U6{1'b0}}, imm_lo[PRED_U_W-1:0]};
    assign idx_scaled = index << shamt;

    always_comb begin
        unique case (mode)
            AM_BASE_OFS: addend = s11_ext << size;
            AM_IDX_ABS:  addend = idx_scaled;
            AM_POST_IMM: addend = s4_ext << size;
            AM_POST_MOD: addend = modifier;
            AM_REG_REG:  addend = idx_scaled;
            AM_PRED_OFS: addend = u6_ext << size;
            default:     addend = '0;
        endcase
    end

endmodule

// File: rtl/agu_addr.sv
module agu_addr
    import agu_pkg::*;
#(
    parameter int unsigned AW = DEF_ADDR_W
) (
    input  amode_e         mode,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  imm,
    input  logic [AW-1:0]  addend,
    output logic [AW-1:0]  ea,
    output logic           wb_req,
    output logic [AW-1:0]  wb_val
);

    logic [AW-1:0] base_sum;
    logic [AW-1:0] abs_sum;

    // all sums wrap at AW bits
    assign base_sum = base + addend;
    assign abs_sum  = addend + imm;

    always_comb begin
        ea     = '0;
        wb_req = 1'b0;
        wb_val = '0;
        unique case (mode)
            AM_BASE_OFS: ea = base_sum;
            AM_IDX_ABS:  ea = abs_sum;
            AM_ABS_SET: begin
                ea     = imm;
                wb_req = 1'b1;
                wb_val = imm;
            end
            AM_POST_IMM, AM_POST_MOD: begin
                ea     = base;
                wb_req = 1'b1;
                wb_val = base_sum;
            end
            AM_REG_REG:  ea = base_sum;
            AM_PRED_OFS: ea = base_sum;
            default: begin
                ea     = '0;
                wb_req = 1'b0;
                wb_val = '0;
            end
        endcase
    end

endmodule

// File: rtl/agu_pred.sv
module agu_pred (
    input  logic pred_en,
    input  logic pred_neg,
    input  logic pred_lsb,
    output logic cancel
);

    logic test_ok;

    // the inverted sense passes when the bit is clear
    assign test_ok = pred_lsb ^ pred_neg;
    assign cancel  = pred_en & ~test_ok;

endmodule

// File: rtl/agu_core.sv
module agu_core
    import agu_pkg::*;
#(
    parameter int unsigned AW = DEF_ADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [2:0]     mode,
    input  logic [1:0]     size,
    input  logic [1:0]     shamt,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  index,
    input  logic [AW-1:0]  modifier,
    input  logic [AW-1:0]  imm,
    input  logic           pred_en,
    input  logic           pred_neg,
    input  logic           pred_lsb,
    output logic           res_valid,
    output logic [AW-1:0]  ea,
    output logic           wb_en,
    output logic [AW-1:0]  wb_val,
    output logic           cancel
);

    amode_e        mode_e;
    logic [AW-1:0] addend_c;
    logic [AW-1:0] ea_c;
    logic          wb_req_c;
    logic [AW-1:0] wb_val_c;
    logic          cancel_c;

    agu_state_e    state_q;
    agu_state_e    state_d;

    logic [AW-1:0] ea_q;
    logic          wb_en_q;
    logic [AW-1:0] wb_val_q;
    logic          cancel_q;

    assign mode_e = amode_e'(mode);

    agu_offset #(.AW(AW)) u_offset (
        .mode     (mode_e),
        .size     (size),
        .shamt    (shamt),
        .imm_lo   (imm[OFS_S_W-1:0]),
        .index    (index),
        .modifier (modifier),
        .addend   (addend_c)
    );

    agu_addr #(.AW(AW)) u_addr (
        .mode   (mode_e),
        .base   (base),
        .imm    (imm),
        .addend (addend_c),
        .ea     (ea_c),
        .wb_req (wb_req_c),
        .wb_val (wb_val_c)
    );

    agu_pred u_pred (
        .pred_en  (pred_en),
        .pred_neg (pred_neg),
        .pred_lsb (pred_lsb),
        .cancel   (cancel_c)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = op_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = op_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q     <= '0;
            wb_en_q  <= 1'b0;
            wb_val_q <= '0;
            cancel_q <= 1'b0;
        end else if (op_valid) begin
            ea_q     <= ea_c;
            wb_en_q  <= wb_req_c & ~cancel_c;
            wb_val_q <= wb_val_c;
            cancel_q <= cancel_c;
        end else begin
            wb_en_q  <= 1'b0;
            cancel_q <= 1'b0;
        end
    end

    assign res_valid = (state_q == ST_RESULT);
    assign ea        = ea_q;
    assign wb_en     = wb_en_q;
    assign wb_val    = wb_val_q;
    assign cancel    = cancel_q;

endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [2:0]    mode,
    input logic [AW-1:0] base,
    input logic [AW-1:0] modifier,
    input logic          pred_en,
    input logic          pred_neg,
    input logic          pred_lsb,
    input logic          res_valid,
    input logic [AW-1:0] ea,
    input logic          wb_en,
    input logic [AW-1:0] wb_val,
    input logic          cancel
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_en && cancel));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!wb_en && !cancel));

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_valid) |=> res_valid);

    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !op_valid) |=> !res_valid);

    p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_valid && pred_en && (pred_lsb == pred_neg)) |=> (cancel && !wb_en));

    p_nocancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_valid && !pred_en) |=> !cancel);

    p_abs_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_valid && !pred_en && mode == 3'd2) |=> (wb_en && wb_val == ea));

    p_post_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_valid && mode == 3'd3) |=> (ea == $past(base)));

    p_post_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && op_valid && mode == 3'd4) |=>
            (ea == $past(base) && wb_val == $past(base) + $past(modifier)));

endmodule

bind agu_core agu_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .mode      (mode),
    .base      (base),
    .modifier  (modifier),
    .pred_en   (pred_en),
    .pred_neg  (pred_neg),
    .pred_lsb  (pred_lsb),
    .res_valid (res_valid),
    .ea        (ea),
    .wb_en     (wb_en),
    .wb_val    (wb_val),
    .cancel    (cancel)
);

// File: tb/sim_agu_core.sv
`timescale 1ns/1ps
module sim_agu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [1:0]  shamt = '0;
    logic [31:0] base = '0;
    logic [31:0] index = '0;
    logic [31:0] modifier = '0;
    logic [31:0] imm = '0;
    logic        pred_en = 1'b0;
    logic        pred_neg = 1'b0;
    logic        pred_lsb = 1'b0;
    logic        res_valid;
    logic [31:0] ea;
    logic        wb_en;
    logic [31:0] wb_val;
    logic        cancel;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] rf [16];

    always #4 clk = ~clk;

    agu_core u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .mode(mode), .size(size),
        .shamt(shamt), .base(base), .index(index), .modifier(modifier), .imm(imm),
        .pred_en(pred_en), .pred_neg(pred_neg), .pred_lsb(pred_lsb),
        .res_valid(res_valid), .ea(ea), .wb_en(wb_en), .wb_val(wb_val), .cancel(cancel)
    );

    function automatic string req_of(input logic [2:0] m, input logic pe);
        if (pe) return "R8";
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R12";
        endcase
    endfunction

    // reference model built from the requirement text
    task automatic model(input logic [2:0] m, input logic [1:0] sz, input logic [1:0] sh,
                         input logic [31:0] b, input logic [31:0] ix, input logic [31:0] md,
                         input logic [31:0] im, input logic pe, input logic pn, input logic pl,
                         output logic [31:0] x_ea, output logic x_wb, output logic [31:0] x_wv,
                         output logic x_cn);
        logic [31:0] s11 = {{21{im[10]}}, im[10:0]};
        logic [31:0] s4  = {{28{im[3]}}, im[3:0]};
        logic [31:0] u6  = {26'd0, im[5:0]};
        x_wb = 1'b0; x_wv = 32'd0; x_ea = 32'd0;
        case (m)
            3'd0: x_ea = b + (s11 << sz);
            3'd1: x_ea = (ix << sh) + im;
            3'd2: begin x_ea = im; x_wb = 1'b1; x_wv = im; end
            3'd3: begin x_ea = b; x_wb = 1'b1; x_wv = b + (s4 << sz); end
            3'd4: begin x_ea = b; x_wb = 1'b1; x_wv = b + md; end
            3'd5: x_ea = b + (ix << sh);
            3'd6: x_ea = b + (u6 << sz);
            default: x_ea = 32'd0;
        endcase
        x_cn = pe && (pl == pn);
        if (x_cn) x_wb = 1'b0;
    endtask

    task automatic run_op(input string tag, input logic [2:0] m, input logic [1:0] sz,
                          input logic [1:0] sh, input logic [31:0] b, input logic [31:0] ix,
                          input logic [31:0] md, input logic [31:0] im, input logic pe,
                          input logic pn, input logic pl, output logic got_wb,
                          output logic [31:0] got_wv);
        logic [31:0] x_ea, x_wv;
        logic x_wb, x_cn;
        bit bad;
        model(m, sz, sh, b, ix, md, im, pe, pn, pl, x_ea, x_wb, x_wv, x_cn);
        mode = m; size = sz; shamt = sh; base = b; index = ix; modifier = md; imm = im;
        pred_en = pe; pred_neg = pn; pred_lsb = pl; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        n_tests++;
        bad = (res_valid !== 1'b1) || (ea !== x_ea) || (wb_en !== x_wb) || (cancel !== x_cn)
              || (x_wb && (wb_val !== x_wv));
        if (bad) begin
            n_fail++;
            $display("FAIL %s mode=%0d: got v=%b ea=%h wb=%b wv=%h cn=%b exp v=1 ea=%h wb=%b wv=%h cn=%b",
                     tag, m, res_valid, ea, wb_en, wb_val, cancel, x_ea, x_wb, x_wv, x_cn);
        end
        got_wb = wb_en;
        got_wv = wb_val;
    endtask

    task automatic check_idle(input string tag);
        n_tests++;
        if (res_valid !== 1'b0 || wb_en !== 1'b0 || cancel !== 1'b0) begin
            n_fail++;
            $display("FAIL %s idle: got v=%b wb=%b cn=%b exp 0 0 0", tag, res_valid, wb_en, cancel);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: got running exp finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic gw;
        logic [31:0] gv;
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) rf[i] = $urandom;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        n_tests++;
        if (res_valid !== 1'b0 || wb_en !== 1'b0 || cancel !== 1'b0 || ea !== 32'd0 || wb_val !== 32'd0) begin
            n_fail++;
            $display("FAIL R11 reset: got v=%b wb=%b cn=%b ea=%h wv=%h exp all zero",
                     res_valid, wb_en, cancel, ea, wb_val);
        end

        // R1 and R9: negative offset, double size
        run_op("R1", 3'd0, 2'd3, 2'd0, 32'h0000_0010, 0, 0, 32'h0000_07FF, 0, 0, 0, gw, gv);
        run_op("R9", 3'd0, 2'd2, 2'd0, 32'h0000_0004, 0, 0, 32'h0000_0400, 0, 0, 0, gw, gv);
        // R2
        run_op("R2", 3'd1, 2'd0, 2'd3, 0, 32'h1000_0001, 0, 32'h0000_0020, 0, 0, 0, gw, gv);
        // R3
        run_op("R3", 3'd2, 2'd1, 2'd0, 0, 0, 0, 32'hCAFE_0040, 0, 0, 0, gw, gv);
        // R4 and R9: wrap past the top with a positive step
        run_op("R9", 3'd3, 2'd3, 2'd0, 32'hFFFF_FFF0, 0, 0, 32'h0000_0007, 0, 0, 0, gw, gv);
        run_op("R4", 3'd3, 2'd1, 2'd0, 32'h0000_0100, 0, 0, 32'h0000_0008, 0, 0, 0, gw, gv);
        // R5
        run_op("R5", 3'd4, 2'd0, 2'd0, 32'h8000_0000, 0, 32'h8000_0004, 0, 0, 0, 0, gw, gv);
        // R6
        run_op("R6", 3'd5, 2'd0, 2'd2, 32'h0000_1000, 32'h0000_0003, 0, 0, 0, 0, 0, gw, gv);
        // R7: unsigned 6-bit offset, word size
        run_op("R7", 3'd6, 2'd2, 2'd0, 32'h0000_2000, 0, 0, 32'h0000_003F, 0, 0, 0, gw, gv);
        // R8: failing predicates on post-increment and absolute set
        run_op("R8", 3'd3, 2'd2, 2'd0, 32'h0000_0400, 0, 0, 32'h0000_0001, 1, 0, 0, gw, gv);
        run_op("R8", 3'd2, 2'd0, 2'd0, 0, 0, 0, 32'h0000_1234, 1, 1, 1, gw, gv);
        run_op("R8", 3'd4, 2'd0, 2'd0, 32'h10, 0, 32'h4, 0, 1, 1, 0, gw, gv);
        // R12
        run_op("R12", 3'd7, 2'd3, 2'd3, 32'hFFFF_FFFF, 32'h1, 32'h1, 32'hFFFF_FFFF, 0, 0, 0, gw, gv);
        // R10: idle after a gap
        @(negedge clk);
        check_idle("R10");

        // random operations using the register file model
        for (int k = 0; k < 400; k++) begin
            int rb = $urandom % 16;
            int ri = $urandom % 16;
            int rm = $urandom % 16;
            int re = $urandom % 16;
            logic [2:0] m = 3'($urandom);
            logic pe = (($urandom % 3) == 0);
            run_op(req_of(m, pe), m, 2'($urandom), 2'($urandom), rf[rb], rf[ri], rf[rm],
                   $urandom, pe, 1'($urandom), 1'($urandom), gw, gv);
            if (gw) begin
                if (m == 3'd2) rf[re] = gv;
                else           rf[rb] = gv;
            end
            if (($urandom % 4) == 0) begin
                @(negedge clk);
                check_idle("R10");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule